// File: doc/BRIEF.md
# Synchronization status frame receiver

This block watches one port's received Ethernet frames, delivered as a byte-wide stream with start and end markers. It picks out synchronization status messages: frames that carry the slow-protocol EtherType and the expected subtype byte. From each such frame it takes a 4-bit quality-level code and an event flag. It does not check the FCS. Instead it trusts a frame-good qualifier that is presented with the last byte.

The block holds the last accepted quality level together with a valid flag. It pulses an output for one cycle whenever the held level changes, and pulses another output when an accepted frame has its event flag set. These messages normally arrive about once per second. A one-second tick input drives a loss-of-message timer. When no accepted frame arrives within a programmable number of ticks, the block forces the level to do-not-use. A port-enable input gates the whole receiver. Five periods is the usual timeout setting.

Top module: `ssm_rx`

## Requirements
- R1: A frame is accepted only if bytes 12 and 13 (counting from 0 at the start-of-frame beat) are 0x88 then 0x09, and byte 14 equals the SUBTYPE parameter (default 0x0A).
- R2: A frame is accepted only if rx_good_i is high on its end-of-frame beat and the frame reached byte 16. Rejected or truncated frames leave the outputs unchanged.
- R3: The quality level is the low nibble of byte 16. The codes 0x2 (PRC), 0x4 (SSU-A), 0x8 (SSU-B), 0xB (SEC) and 0xF (DNU) are held as received. Any other code is held as 0xF.
- R4: On acceptance, ql_o takes the new level and ql_valid_o goes high in the cycle after the end-of-frame beat.
- R5: ql_changed_o pulses for exactly one cycle, in the same cycle that ql_o shows a new value. This includes changes caused by timeout or disable. It stays low when an accepted frame repeats the held level.
- R6: event_o pulses for one cycle, in the cycle after the end-of-frame beat, when an accepted frame has bit 3 of byte 15 set.
- R7: After timeout_i tick pulses with no accepted frame since the last accepted one, ql_o becomes 0xF and ql_valid_o goes low. An accepted frame restarts the count.
- R8: While port_en_i is low, ql_o is 0xF and ql_valid_o is low, and frames are ignored.
- R9: After reset, ql_o is 0xF, and ql_valid_o, ql_changed_o and event_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_en_i | input | 1 | Port enable |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Byte strobe |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_good_i | input | 1 | Frame good, sampled on the end-of-frame beat |
| sec_tick_i | input | 1 | One-cycle pulse per message period |
| timeout_i | input | TO_W | Loss-of-message limit in ticks |
| ql_o | output | 4 | Held quality level |
| ql_valid_o | output | 1 | Held level came from a live message |
| ql_changed_o | output | 1 | One-cycle pulse on a new held level |
| event_o | output | 1 | One-cycle pulse on an accepted event flag |

## Verification
The bench sends frames with a wrong EtherType, a wrong subtype, a bad frame-good qualifier or an early end-of-frame. A design that skipped any one of these filters would let the held level move. It repeats a level to catch a change pulse that fires on every frame rather than on every new value. It also feeds an undefined code, which a design without normalization would pass through unchanged.

For the timer, the bench checks the cycle one tick short of the limit and the cycle at the limit, and checks that a frame arriving mid-count restarts the timer. An off-by-one counter, or one that a frame does not clear, would drop to DNU at the wrong tick. Finally, it disables the port while frames are still arriving, which exposes a design that keeps accepting messages or fails to report DNU.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef logic [3:0] ql_t;

  localparam ql_t QL_PRC  = 4'h2;
  localparam ql_t QL_SSUA = 4'h4;
  localparam ql_t QL_SSUB = 4'h8;
  localparam ql_t QL_SEC  = 4'hB;
  localparam ql_t QL_DNU  = 4'hF;

  function automatic logic ql_legal(ql_t q);
    return (q == QL_PRC) || (q == QL_SSUA) || (q == QL_SSUB) ||
           (q == QL_SEC) || (q == QL_DNU);
  endfunction

  function automatic ql_t ql_norm(ql_t q);
    return ql_legal(q) ? q : QL_DNU;
  endfunction
endpackage

// File: rtl/ssm_frame_parser.sv
module ssm_frame_parser
  import ssm_pkg::*;
#(
  parameter logic [7:0] SUBTYPE   = 8'h0A,
  parameter int         EVT_BIT   = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic       good_i,
  output logic       accept_o,
  output ql_t        ql_o,
  output logic       evt_o
);
  localparam int TYPE_OFF = 12;
  localparam int SUB_OFF  = 14;
  localparam int EVT_OFF  = 15;
  localparam int QL_OFF   = 16;
  localparam int CNT_W    = $clog2(QL_OFF + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, off;
  logic in_frame_q, act;
  logic thi_q, tlo_q, sub_q, seen_q, evt_q;
  logic thi_n, tlo_n, sub_n, seen_n, evt_n;
  ql_t  ql_q, ql_n;

  assign act = en_i && valid_i && (sof_i || in_frame_q);
  assign off = sof_i ? '0 : cnt_q;

  always_comb begin
    thi_n  = sof_i ? 1'b0 : thi_q;
    tlo_n  = sof_i ? 1'b0 : tlo_q;
    sub_n  = sof_i ? 1'b0 : sub_q;
    seen_n = sof_i ? 1'b0 : seen_q;
    evt_n  = sof_i ? 1'b0 : evt_q;
    ql_n   = ql_q;
    if (off == CNT_W'(TYPE_OFF))     thi_n = (data_i == 8'h88);
    if (off == CNT_W'(TYPE_OFF + 1)) tlo_n = (data_i == 8'h09);
    if (off == CNT_W'(SUB_OFF))      sub_n = (data_i == SUBTYPE);
    if (off == CNT_W'(EVT_OFF))      evt_n = data_i[EVT_BIT];
    if (off == CNT_W'(QL_OFF)) begin
      seen_n = 1'b1;
      ql_n   = data_i[3:0];
    end
  end

  assign accept_o = act && eof_i && good_i && thi_n && tlo_n && sub_n && seen_n;
  assign ql_o     = ql_n;
  assign evt_o    = evt_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; in_frame_q <= 1'b0;
      thi_q <= 1'b0; tlo_q <= 1'b0; sub_q <= 1'b0; seen_q <= 1'b0; evt_q <= 1'b0;
      ql_q  <= QL_DNU;
    end else if (!en_i) begin
      in_frame_q <= 1'b0;
    end else if (act) begin
      in_frame_q <= !eof_i;
      cnt_q <= (off == CNT_MAX) ? CNT_MAX : off + 1'b1;
      thi_q <= thi_n; tlo_q <= tlo_n; sub_q <= sub_n; seen_q <= seen_n; evt_q <= evt_n;
      ql_q  <= ql_n;
    end
  end

  // R2
  accept_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (eof_i && good_i && en_i));
endmodule

// File: rtl/ssm_loss_timer.sv
module ssm_loss_timer #(
  parameter int TO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            restart_i,
  input  logic            tick_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q;
  logic            armed_q;
  logic [TO_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign expire_o = armed_q && tick_i && !restart_i && !clear_i &&
                    (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; armed_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0; armed_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0; armed_q <= 1'b1;
    end else if (expire_o) begin
      armed_q <= 1'b0;
    end else if (armed_q && tick_i) begin
      cnt_q <= cnt_inc[TO_W-1:0];
    end
  end

  // R7
  expire_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !armed_q);
endmodule

// File: rtl/ssm_rx.sv
module ssm_rx
  import ssm_pkg::*;
#(
  parameter int         TO_W    = 8,
  parameter logic [7:0] SUBTYPE = 8'h0A
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            port_en_i,
  input  logic [7:0]      rx_data_i,
  input  logic            rx_valid_i,
  input  logic            rx_sof_i,
  input  logic            rx_eof_i,
  input  logic            rx_good_i,
  input  logic            sec_tick_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic [3:0]      ql_o,
  output logic            ql_valid_o,
  output logic            ql_changed_o,
  output logic            event_o
);
  logic accept, evt, expire;
  ql_t  rx_ql, ql_q, ql_n;
  logic val_q, val_n, chg_q, evt_q;

  ssm_frame_parser #(.SUBTYPE(SUBTYPE), .EVT_BIT(3)) u_parser (
    .clk_i, .rst_ni, .en_i(port_en_i),
    .data_i(rx_data_i), .valid_i(rx_valid_i), .sof_i(rx_sof_i),
    .eof_i(rx_eof_i), .good_i(rx_good_i),
    .accept_o(accept), .ql_o(rx_ql), .evt_o(evt)
  );

  ssm_loss_timer #(.TO_W(TO_W)) u_timer (
    .clk_i, .rst_ni, .clear_i(!port_en_i), .restart_i(accept),
    .tick_i(sec_tick_i), .limit_i(timeout_i), .expire_o(expire)
  );

  always_comb begin
    ql_n  = ql_q;
    val_n = val_q;
    if (!port_en_i) begin
      ql_n = QL_DNU; val_n = 1'b0;
    end else if (accept) begin
      ql_n = ql_norm(rx_ql); val_n = 1'b1;
    end else if (expire) begin
      ql_n = QL_DNU; val_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ql_q <= QL_DNU; val_q <= 1'b0; chg_q <= 1'b0; evt_q <= 1'b0;
    end else begin
      ql_q  <= ql_n;
      val_q <= val_n;
      chg_q <= (ql_n != ql_q);
      evt_q <= accept && evt;
    end
  end

  assign ql_o         = ql_q;
  assign ql_valid_o   = val_q;
  assign ql_changed_o = chg_q;
  assign event_o      = evt_q;

  // R3
  ql_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ql_legal(ql_o));
  // R5
  chg_new_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ql_changed_o |-> (ql_o != $past(ql_o)));
  // R6
  event_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> ql_valid_o);
  // R8
  disabled_dnu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> (ql_o == QL_DNU && !ql_valid_o));
endmodule

// File: tb/tb_ssm_rx.sv
module tb_ssm_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [7:0] data = '0;
  logic       vld = 1'b0, sof = 1'b0, eof = 1'b0, good = 1'b0, tick = 1'b0;
  logic [7:0] tmo = 8'd5;
  logic [3:0] ql;
  logic       qv, chg, evt;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  ssm_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(en), .rx_data_i(data),
    .rx_valid_i(vld), .rx_sof_i(sof), .rx_eof_i(eof), .rx_good_i(good),
    .sec_tick_i(tick), .timeout_i(tmo),
    .ql_o(ql), .ql_valid_o(qv), .ql_changed_o(chg), .event_o(evt)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // check = ql, valid, changed, event packed
  task automatic expect_state(string req, logic [3:0] eql, logic ev, logic ec, logic ee);
    check(req, {ql, 1'b0, qv, chg, evt}, {eql, 1'b0, ev, ec, ee});
  endtask

  // Sends a frame; returns at the negedge after the end-of-frame edge.
  task automatic send(logic [15:0] et, logic [7:0] sub, logic [7:0] flg,
                      logic [7:0] qb, int len, logic g);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      vld = 1'b1; sof = (i == 0); eof = (i == len - 1); good = (i == len - 1) && g;
      case (i)
        12: data = et[15:8];
        13: data = et[7:0];
        14: data = sub;
        15: data = flg;
        16: data = qb;
        default: data = 8'(i + 8'h30);
      endcase
    end
    @(negedge clk);
    vld = 1'b0; sof = 1'b0; eof = 1'b0; good = 1'b0;
  endtask

  task automatic ok_frame(logic [3:0] q, logic e);
    send(16'h8809, 8'h0A, {4'h0, e, 3'b000}, {4'h0, q}, 20, 1'b1);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    expect_state("R9 reset", 4'hF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_accept();
    ok_frame(4'h2, 1'b0);
    expect_state("R4 accept PRC", 4'h2, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    expect_state("R5 pulse one cycle", 4'h2, 1'b1, 1'b0, 1'b0);
    ok_frame(4'h2, 1'b0);
    expect_state("R5 repeat no pulse", 4'h2, 1'b1, 1'b0, 1'b0);
    ok_frame(4'h8, 1'b1);
    expect_state("R6 SSU-B with event", 4'h8, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R6 event one cycle", {7'd0, evt}, 8'd0);
    ok_frame(4'hB, 1'b0);
    expect_state("R3 SEC", 4'hB, 1'b1, 1'b1, 1'b0);
    ok_frame(4'h4, 1'b0);
    expect_state("R3 SSU-A", 4'h4, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_filters();
    send(16'h8808, 8'h0A, 8'h08, 8'h02, 20, 1'b1);
    expect_state("R1 wrong ethertype", 4'h4, 1'b1, 1'b0, 1'b0);
    send(16'h8809, 8'h0B, 8'h08, 8'h02, 20, 1'b1);
    expect_state("R1 wrong subtype", 4'h4, 1'b1, 1'b0, 1'b0);
    send(16'h8809, 8'h0A, 8'h08, 8'h02, 20, 1'b0);
    expect_state("R2 frame bad", 4'h4, 1'b1, 1'b0, 1'b0);
    send(16'h8809, 8'h0A, 8'h08, 8'h02, 16, 1'b1);
    expect_state("R2 truncated", 4'h4, 1'b1, 1'b0, 1'b0);
    send(16'h8809, 8'h0A, 8'h00, 8'h02, 17, 1'b1);
    expect_state("R2 minimum length", 4'h2, 1'b1, 1'b1, 1'b0);
    ok_frame(4'h5, 1'b0);
    expect_state("R3 undefined code", 4'hF, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_timeout();
    tmo = 8'd3;
    ok_frame(4'h2, 1'b0);
    pulse_tick(); pulse_tick();
    ok_frame(4'h2, 1'b0);
    pulse_tick(); pulse_tick();
    expect_state("R7 restart by frame", 4'h2, 1'b1, 1'b0, 1'b0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    expect_state("R7 expired", 4'hF, 1'b0, 1'b1, 1'b0);
    pulse_tick();
    expect_state("R7 stays DNU", 4'hF, 1'b0, 1'b0, 1'b0);
    tmo = 8'd5;
  endtask

  task automatic t_disable();
    ok_frame(4'h8, 1'b0);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    expect_state("R8 disable to DNU", 4'hF, 1'b0, 1'b1, 1'b0);
    ok_frame(4'h2, 1'b1);
    expect_state("R8 frame ignored", 4'hF, 1'b0, 1'b0, 1'b0);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    expect_state("R8 re-enable idle", 4'hF, 1'b0, 1'b0, 1'b0);
    ok_frame(4'h2, 1'b0);
    expect_state("R8 receive after enable", 4'h2, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_accept();
    t_filters();
    t_timeout();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule